// File: doc/BRIEF.md
# Serial data lane translator

This block sits on a memory module between two dedicated serial data lines and four byte-wide memory devices. Toward the host, it gathers one byte from each device into a 32-bit word and sends that word out on a single serial line, most significant bit first. From the host, it collects 32 serial bits into a word and hands one byte of that word to each device. All four bytes are handed over at once.

The block runs on the fast bit clock. A word strobe, one bit-clock cycle wide and pulsed once per memory cycle, frames the work in both directions. On the read side, the strobe captures the four device bytes and starts a 32-bit shift-out. On the write side, it marks the bit that is sampled in the same cycle as the first bit of an incoming word. Each word takes exactly 32 bit-clock cycles on its line. A strobe every 32 cycles therefore keeps both lines fully busy, with no idle bits between words. The serial link then carries the same bandwidth as the byte-wide devices.

Top module: `lane_xlate`

## Requirements
- R1: After a synchronous reset, ser_out, rd_busy and wr_valid are 0 and dev_d is all zeros.
- R2: A strobe sampled while rd_busy is 0 captures all four device bytes on that edge. rd_busy is then 1 for exactly 32 cycles, starting in the next cycle.
- R3: The captured word goes out on ser_out in bit order 31 down to 0, one bit per cycle, with bit 31 in the first busy cycle. Device lane i occupies word bits 8i+7 to 8i, so lane 3 goes out first and lane 0 last.
- R4: A strobe sampled while more than one bit of the current word remains is ignored. Changes on dev_q after the capture do not alter the bits being sent.
- R5: A strobe sampled in the cycle that shows the last bit (bit 0) of a word loads the next word. Its bit 31 appears in the very next cycle, with rd_busy held at 1 and no gap.
- R6: ser_out is 0 whenever rd_busy is 0.
- R7: The ser_in bit sampled on a strobe edge is bit 31 of a write word. The bits on the following 31 edges are bits 30 down to 0. Byte i of the word is driven on dev_d bits 8i+7 to 8i.
- R8: dev_d changes only when a write word completes, with all four bytes updated on the same edge. wr_valid is a one-cycle pulse in the cycle after the 32nd bit is sampled.
- R9: A strobe that arrives before 32 bits have been received discards the partial word and restarts reception with the sampled bit as bit 31. dev_d keeps its old value and no wr_valid pulse is given for the discarded bits.
- R10: Write words whose strobes are exactly 32 cycles apart are each delivered, with one wr_valid pulse every 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | One-cycle word strobe, once per memory cycle |
| dev_q | input | 32 | Bytes read from the four devices, lane i at bits 8i+7:8i |
| ser_out | output | 1 | Serial read data toward the host |
| rd_busy | output | 1 | High while a read word is being shifted out |
| ser_in | input | 1 | Serial write data from the host |
| dev_d | output | 32 | Bytes to the four devices, lane i at bits 8i+7:8i |
| wr_valid | output | 1 | One-cycle pulse when dev_d holds a new complete word |

## Verification
A wrong shift count in the read path shows on rd_busy within one word time: the busy window comes out longer or shorter than 32 cycles, or a back-to-back reload opens a gap of one idle cycle. A wrong lane order or carry between the byte registers shows on ser_out within the first eight bits of a word. In the write path, a wrong bit count moves the wr_valid pulse away from the 32nd cycle after the strobe. A wrong lane slice, or an early commit, shows on dev_d at the pulse, or between pulses as a change with no pulse. The bench therefore compares every port in every cycle against a model built from the requirements, so any such fault is reported in the cycle it first reaches a pin.

// File: rtl/lane_xlate_pkg.sv
package lane_xlate_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 8;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_phase_t;

    function automatic int word_bits(input int lanes, input int lane_w);
        return lanes * lane_w;
    endfunction

    function automatic int count_bits(input int lanes, input int lane_w);
        return $clog2(lanes * lane_w + 1);
    endfunction

endpackage

// File: rtl/lane_tx_serializer.sv
module lane_tx_serializer
    import lane_xlate_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load_req,
    input  logic [word_bits(LANES,LANE_W)-1:0] par_in,
    output logic                               bit_out,
    output logic                               busy
);
    localparam int W     = word_bits(LANES, LANE_W);
    localparam int CNT_W = count_bits(LANES, LANE_W);

    logic [CNT_W-1:0] cnt;
    logic             take;
    logic             shifting;

    // accept when idle or while the last bit is on the line
    assign take     = load_req && (cnt <= CNT_W'(1));
    assign shifting = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (take)    cnt <= CNT_W'(W);
        else if (shifting) cnt <= cnt - CNT_W'(1);
    end

    // one byte register per lane, chained so the word shifts as a whole
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] q;
        logic              carry;
        if (g == 0) begin : g_first
            assign carry = 1'b0;
        end else begin : g_next
            assign carry = g_lane[g-1].q[LANE_W-1];
        end
        always_ff @(posedge clk) begin
            if (rst)           q <= '0;
            else if (take)     q <= par_in[g*LANE_W +: LANE_W];
            else if (shifting) q <= {q[LANE_W-2:0], carry};
        end
    end

    assign busy    = shifting;
    assign bit_out = shifting & g_lane[LANES-1].q[LANE_W-1];

    // R2: an accepted strobe makes the shifter busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_req) && ($past(cnt) <= CNT_W'(1))) |-> busy);

    // R4: with more than one bit left, the count only steps down
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R2: the count never exceeds one word
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(W));

endmodule

// File: rtl/lane_rx_deserializer.sv
module lane_rx_deserializer
    import lane_xlate_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               frame_start,
    input  logic                               bit_in,
    output logic [word_bits(LANES,LANE_W)-1:0] par_out,
    output logic                               word_done
);
    localparam int W     = word_bits(LANES, LANE_W);
    localparam int CNT_W = count_bits(LANES, LANE_W);
    localparam int SH_W  = W - 1;

    rx_phase_t        phase;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic [W-1:0]     full_word;
    logic             commit;

    assign full_word = {sh, bit_in};
    assign commit    = (phase == RX_FILL) && !frame_start && (cnt == CNT_W'(W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= RX_IDLE;
            cnt       <= '0;
            sh        <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (frame_start) begin
                sh    <= SH_W'(bit_in);
                cnt   <= CNT_W'(1);
                phase <= RX_FILL;
            end else if (phase == RX_FILL) begin
                if (commit) begin
                    word_done <= 1'b1;
                    phase     <= RX_IDLE;
                    cnt       <= '0;
                end else begin
                    sh  <= {sh[SH_W-2:0], bit_in};
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // output byte per lane, all loaded on the same completing edge
    for (genvar g = 0; g < LANES; g++) begin : g_out
        logic [LANE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (commit) q <= full_word[g*LANE_W +: LANE_W];
        end
        assign par_out[g*LANE_W +: LANE_W] = q;
    end

    // R8: completion pulse lasts one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    // R8: device bytes hold between completions
    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !word_done) |-> $stable(par_out));

    // R7: a completion follows a filling phase
    a_r7_done_from_fill: assert property (@(posedge clk) disable iff (rst)
        word_done |-> ($past(phase) == RX_FILL));

    // R9: an idle receiver keeps no partial count
    a_r9_idle_count: assert property (@(posedge clk) disable iff (rst)
        (phase == RX_IDLE) |-> (cnt == '0));

endmodule

// File: rtl/lane_xlate.sv
module lane_xlate
    import lane_xlate_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     word_stb,
    input  logic [LANES*LANE_W-1:0]  dev_q,
    output logic                     ser_out,
    output logic                     rd_busy,
    input  logic                     ser_in,
    output logic [LANES*LANE_W-1:0]  dev_d,
    output logic                     wr_valid
);

    lane_tx_serializer #(.LANES(LANES), .LANE_W(LANE_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load_req (word_stb),
        .par_in   (dev_q),
        .bit_out  (ser_out),
        .busy     (rd_busy)
    );

    lane_rx_deserializer #(.LANES(LANES), .LANE_W(LANE_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (word_stb),
        .bit_in      (ser_in),
        .par_out     (dev_d),
        .word_done   (wr_valid)
    );

    // R6: line is quiet whenever no read word is in flight
    a_r6_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_busy |-> !ser_out);

    // R8: device bytes never change without a completion pulse
    a_r8_no_silent_change: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(dev_d)) |-> wr_valid);

endmodule

// File: tb/lane_xlate_test.sv
module lane_xlate_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_stb;
    logic [31:0] dev_q;
    logic        ser_out;
    logic        rd_busy;
    logic        ser_in;
    logic [31:0] dev_d;
    logic        wr_valid;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // reference model state
    int          m_rcnt = 0;
    logic [31:0] m_rsh  = '0;
    int          m_wcnt = 0;
    logic [31:0] m_wsh  = '0;
    logic [31:0] m_dd   = '0;
    logic        m_vld  = 1'b0;

    always #2.5 clk = ~clk;

    lane_xlate uut (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb),
        .dev_q    (dev_q),
        .ser_out  (ser_out),
        .rd_busy  (rd_busy),
        .ser_in   (ser_in),
        .dev_d    (dev_d),
        .wr_valid (wr_valid)
    );

    function automatic logic exp_ser();
        return (m_rcnt > 0) ? m_rsh[31] : 1'b0;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("ser_out", 32'(ser_out), 32'(exp_ser()));
        chk("rd_busy", 32'(rd_busy), 32'(m_rcnt > 0));
        chk("dev_d", dev_d, m_dd);
        chk("wr_valid", 32'(wr_valid), 32'(m_vld));
    endtask

    // apply inputs, advance one edge in the model, compare at the next falling edge
    task automatic tick(input logic s, input logic b, input logic [31:0] q);
        word_stb = s;
        ser_in   = b;
        dev_q    = q;
        if (s && m_rcnt <= 1) begin
            m_rsh  = q;
            m_rcnt = 32;
        end else if (m_rcnt > 0) begin
            m_rsh  = m_rsh << 1;
            m_rcnt = m_rcnt - 1;
        end
        m_vld = 1'b0;
        if (s) begin
            m_wsh  = {31'b0, b};
            m_wcnt = 1;
        end else if (m_wcnt > 0) begin
            if (m_wcnt == 31) begin
                m_dd   = {m_wsh[30:0], b};
                m_vld  = 1'b1;
                m_wcnt = 0;
            end else begin
                m_wsh  = {m_wsh[30:0], b};
                m_wcnt = m_wcnt + 1;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic send_write(input logic [31:0] w);
        for (int k = 31; k >= 0; k--) tick(k == 31, w[k], $urandom);
    endtask

    initial begin
        void'($urandom(32'd1759));
        rst = 1'b1; word_stb = 1'b0; ser_in = 1'b0; dev_q = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        compare_all();
        chk("reset ser_out", 32'(ser_out), 32'd0);
        chk("reset dev_d", dev_d, 32'd0);

        // R2 / R3: single read word, lane 3 first
        tag = "R2/R3";
        tick(1'b1, 1'b0, 32'hA5C3_1E7F);
        for (int k = 0; k < 33; k++) tick(1'b0, 1'b0, 32'hFFFF_FFFF);

        // R6: idle line stays low with full-ones on the device bytes
        tag = "R6";
        for (int k = 0; k < 8; k++) tick(1'b0, 1'b1, 32'hFFFF_FFFF);

        // R4: strobe mid-word and device changes are ignored
        tag = "R4";
        tick(1'b1, 1'b0, 32'h8001_7FFE);
        for (int k = 0; k < 36; k++) tick((k == 9) || (k == 29), 1'b0, $urandom);

        // R5: back-to-back read words with no gap
        tag = "R5";
        for (int w = 0; w < 3; w++) begin
            tick(1'b1, 1'b0, 32'h1357_9BDF ^ (w * 32'h0F0F_0F0F));
            for (int k = 0; k < 31; k++) tick(1'b0, 1'b0, $urandom);
        end
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, '0);

        // R7: one write word, byte lanes checked directly
        tag = "R7";
        send_write(32'h1234_56F8);
        tick(1'b0, 1'b0, '0);
        chk("lane0", 32'(dev_d[7:0]), 32'hF8);
        chk("lane3", 32'(dev_d[31:24]), 32'h12);
        for (int k = 0; k < 34; k++) tick(1'b0, 1'b0, '0);

        // R9: partial word discarded by an early strobe
        tag = "R9";
        for (int k = 31; k >= 17; k--) tick(k == 31, 1'b1, '0);
        tick(1'b0, 1'b0, '0);
        send_write(32'hDEAD_0B0E);
        tick(1'b0, 1'b0, '0);
        chk("restart word", dev_d, 32'hDEAD_0B0E);
        for (int k = 0; k < 34; k++) tick(1'b0, 1'b0, '0);

        // R10: back-to-back write words
        tag = "R10";
        send_write(32'h0000_0001);
        send_write(32'h8000_0000);
        send_write(32'hC3C3_3C3C);
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, '0);

        // R8: random traffic in both directions
        tag = "R8";
        for (int k = 0; k < 3000; k++) tick(($urandom % 20) == 0, 1'($urandom), $urandom);
        for (int k = 0; k < 40; k++) tick(1'b0, 1'b0, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s act=running exp=finished", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule